// File: doc/BRIEF.md
# Dual-Width Conditional ALU

This block is the execute stage of a small integer datapath. An instruction is presented on its inputs in one cycle. The block works out a result, a write-back enable for the destination register and the next value of the four condition flags, all combinationally. A flag register inside the block holds the flags for the next instruction. The register file and the instruction decoder sit outside the block. They supply the first operand, the second operand register, a 7-bit immediate and the decoded control fields.

Ten operations are supported. Four are arithmetic: add, subtract, add with carry and subtract with borrow. Two compare: plain compare and compare with borrow. Four are bitwise: AND, OR, XOR and one's complement. All of them run on 16 bits. Add, subtract and compare may instead run on 24 bits, for address arithmetic. A condition field can make an instruction depend on the carry flag. When the condition is not met, the instruction writes nothing and changes no flag.

The only state element is the flag register. It has one state per flag value. On each clock edge it moves to the flag value chosen by the operation, or stays where it is when the instruction is idle, suppressed or reserved. Reset forces it to all zeros.

Top module: `dwc_alu`

## Requirements
- R1: Operation codes on `op_i` are 0 add, 1 subtract, 2 add-with-carry, 3 subtract-with-borrow, 4 compare, 5 compare-with-borrow, 6 AND, 7 OR, 8 XOR, 9 NOT. Add gives a+b, add-with-carry gives a+b+C, subtract gives a-b, and subtract-with-borrow gives a-b-C. Each result is taken modulo 2^W, where W is the active width.
- R2: The flag vector has C in bit 0, Z in bit 1, N in bit 2 and V in bit 3. Z is set when the W-bit result is zero. N is bit W-1 of the result. V is set when the signed result cannot be represented in W bits. For additions, C is the carry out of bit W-1. For subtractions and compares, C is set when a borrow occurs, meaning the unsigned minuend is smaller than the subtrahend plus the incoming borrow.
- R3: Compare (a-b) and compare-with-borrow (a-b-C) update the flags like a subtraction but never assert `wr_en_o`.
- R4: AND, OR and XOR combine a and b bitwise. NOT returns the one's complement of b alone. All four clear C and V.
- R5: `wide_i`=1 selects 24-bit width for add, subtract and compare only. Every other operation, and any operation with `wide_i`=0, works on 16 bits. At 16 bits, `result_o[23:16]` is 0.
- R6: When `use_imm_i`=1 the second operand is `imm_i`. It is zero-extended when `imm_signed_i`=0 and sign-extended from bit 6 when `imm_signed_i`=1. Otherwise the second operand is `b_i`.
- R7: `cond_i` selects 0 always, 1 only when C=1, 2 only when C=0. Code 3 behaves as always.
- R8: When `valid_i`=0 or the condition fails, `wr_en_o` is 0 and `flags_next_o` equals `flags_o`.
- R9: `flags_o` takes the value of `flags_next_o` on every rising clock edge. It resets to 0 while `rst_n` is low.
- R10: Operation codes 10 to 15 are reserved. They give `result_o`=0 and `wr_en_o`=0, and the flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| valid_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | Request 24-bit width |
| cond_i | input | 2 | Carry condition qualifier |
| use_imm_i | input | 1 | Second operand from the immediate |
| imm_signed_i | input | 1 | Sign-extend the immediate |
| imm_i | input | 7 | Immediate value |
| a_i | input | 24 | First operand |
| b_i | input | 24 | Second operand register |
| result_o | output | 24 | Result, zero above the active width |
| wr_en_o | output | 1 | Write back the result |
| flags_next_o | output | 4 | Flags after this instruction {V,N,Z,C} |
| flags_o | output | 4 | Current flag register {V,N,Z,C} |

## Verification
Two cases are hard to reach from the ports. The first is signed overflow in subtract-with-borrow when the second operand is the most positive value and the borrow is set. This needs the right flag value left behind by the instruction before. The second is a suppressed conditional instruction, which needs the carry state to oppose the condition field. The stimulus sets these up with directed pairs: one instruction fixes C, and the next exercises the case. Thousands of random instructions follow. Their operands are biased toward extreme values, and they run against a model flag register in the bench, so every condition code meets both carry states many times.

// File: rtl/dwc_alu_pkg.sv
package dwc_alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_SUB = 4'd1, OP_ADC = 4'd2, OP_SBC = 4'd3,
        OP_CMP = 4'd4, OP_CMC = 4'd5, OP_AND = 4'd6, OP_OR  = 4'd7,
        OP_XOR = 4'd8, OP_NOT = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        CND_ALWAYS = 2'd0, CND_CSET = 2'd1, CND_CCLR = 2'd2, CND_SPARE = 2'd3
    } alu_cond_e;

    typedef enum logic [1:0] {
        CLS_ADD, CLS_SUB, CLS_LOGIC, CLS_NONE
    } alu_cls_e;

    localparam int FLAG_C = 0;
    localparam int FLAG_Z = 1;
    localparam int FLAG_N = 2;
    localparam int FLAG_V = 3;
    localparam int FLAG_W = 4;
endpackage

// File: rtl/dwc_operand_sel.sv
module dwc_operand_sel #(
    parameter int DATA_W = 24,
    parameter int IMM_W  = 7
) (
    input  logic [DATA_W-1:0] reg_val_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic              imm_signed_i,
    output logic [DATA_W-1:0] operand_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic [PAD_W-1:0] pad;

    always_comb begin
        pad = imm_signed_i ? {PAD_W{imm_i[IMM_W-1]}} : '0;
        operand_o = use_imm_i ? {pad, imm_i} : reg_val_i;
    end
endmodule

// File: rtl/dwc_arith_lane.sv
module dwc_arith_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o
);
    logic into_msb;
    logic out_msb;

    always_comb begin
        if (sub_i) begin
            res_o = a_i - b_i - {{(W-1){1'b0}}, cin_i};
        end else begin
            res_o = a_i + b_i + {{(W-1){1'b0}}, cin_i};
        end
        into_msb = res_o[W-1] ^ a_i[W-1] ^ b_i[W-1];
        if (sub_i) begin
            out_msb = (~a_i[W-1] & b_i[W-1]) | (~a_i[W-1] & into_msb)
                    | (b_i[W-1] & into_msb);
        end else begin
            out_msb = (a_i[W-1] & b_i[W-1]) | (a_i[W-1] & into_msb)
                    | (b_i[W-1] & into_msb);
        end
        carry_o = out_msb;
        ovf_o   = into_msb ^ out_msb;
    end
endmodule

// File: rtl/dwc_flag_reg.sv
module dwc_flag_reg #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] flags_d,
    output logic [FW-1:0] flags_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end
endmodule

// File: rtl/dwc_alu.sv
module dwc_alu
    import dwc_alu_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 24,
    parameter int IMM_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [3:0]          op_i,
    input  logic                wide_i,
    input  logic [1:0]          cond_i,
    input  logic                use_imm_i,
    input  logic                imm_signed_i,
    input  logic [IMM_W-1:0]    imm_i,
    input  logic [WIDE_W-1:0]   a_i,
    input  logic [WIDE_W-1:0]   b_i,
    output logic [WIDE_W-1:0]   result_o,
    output logic                wr_en_o,
    output logic [FLAG_W-1:0]   flags_next_o,
    output logic [FLAG_W-1:0]   flags_o
);
    localparam int PAD_W = WIDE_W - NARROW_W;

    alu_op_e             op;
    alu_cls_e            cls;
    logic                wide_eff;
    logic                use_cin;
    logic                no_write;
    logic                cond_ok;
    logic [WIDE_W-1:0]   b_sel;
    logic                cin;
    logic                lane_sub;

    logic [NARROW_W-1:0] n_res;
    logic                n_c;
    logic                n_v;
    logic [WIDE_W-1:0]   w_res;
    logic                w_c;
    logic                w_v;
    logic [NARROW_W-1:0] logic_res;
    logic [FLAG_W-1:0]   flags_calc;
    logic                calc_c;
    logic                calc_v;

    // Operation decode into class, width and write-back behaviour
    always_comb begin
        op       = alu_op_e'(op_i);
        cls      = CLS_NONE;
        use_cin  = 1'b0;
        no_write = 1'b0;
        wide_eff = 1'b0;
        unique case (op)
            OP_ADD:  begin cls = CLS_ADD; wide_eff = wide_i; end
            OP_ADC:  begin cls = CLS_ADD; use_cin = 1'b1; end
            OP_SUB:  begin cls = CLS_SUB; wide_eff = wide_i; end
            OP_SBC:  begin cls = CLS_SUB; use_cin = 1'b1; end
            OP_CMP:  begin cls = CLS_SUB; wide_eff = wide_i; no_write = 1'b1; end
            OP_CMC:  begin cls = CLS_SUB; use_cin = 1'b1; no_write = 1'b1; end
            OP_AND, OP_OR, OP_XOR, OP_NOT: cls = CLS_LOGIC;
            default: begin cls = CLS_NONE; no_write = 1'b1; end
        endcase
        cin      = use_cin & flags_o[FLAG_C];
        lane_sub = (cls == CLS_SUB);
    end

    // Carry condition qualifier
    always_comb begin
        unique case (alu_cond_e'(cond_i))
            CND_CSET: cond_ok = flags_o[FLAG_C];
            CND_CCLR: cond_ok = ~flags_o[FLAG_C];
            default:  cond_ok = 1'b1;
        endcase
    end

    dwc_operand_sel #(.DATA_W(WIDE_W), .IMM_W(IMM_W)) u_opsel (
        .reg_val_i    (b_i),
        .imm_i        (imm_i),
        .use_imm_i    (use_imm_i),
        .imm_signed_i (imm_signed_i),
        .operand_o    (b_sel)
    );

    dwc_arith_lane #(.W(NARROW_W)) u_lane_n (
        .a_i     (a_i[NARROW_W-1:0]),
        .b_i     (b_sel[NARROW_W-1:0]),
        .cin_i   (cin),
        .sub_i   (lane_sub),
        .res_o   (n_res),
        .carry_o (n_c),
        .ovf_o   (n_v)
    );

    dwc_arith_lane #(.W(WIDE_W)) u_lane_w (
        .a_i     (a_i),
        .b_i     (b_sel),
        .cin_i   (cin),
        .sub_i   (lane_sub),
        .res_o   (w_res),
        .carry_o (w_c),
        .ovf_o   (w_v)
    );

    // Bitwise unit, always narrow
    always_comb begin
        unique case (op)
            OP_AND:  logic_res = a_i[NARROW_W-1:0] & b_sel[NARROW_W-1:0];
            OP_OR:   logic_res = a_i[NARROW_W-1:0] | b_sel[NARROW_W-1:0];
            OP_XOR:  logic_res = a_i[NARROW_W-1:0] ^ b_sel[NARROW_W-1:0];
            default: logic_res = ~b_sel[NARROW_W-1:0];
        endcase
    end

    // Result and raw flag selection
    always_comb begin
        calc_c = 1'b0;
        calc_v = 1'b0;
        unique case (cls)
            CLS_ADD, CLS_SUB: begin
                if (wide_eff) begin
                    result_o = w_res;
                    calc_c   = w_c;
                    calc_v   = w_v;
                end else begin
                    result_o = {{PAD_W{1'b0}}, n_res};
                    calc_c   = n_c;
                    calc_v   = n_v;
                end
            end
            CLS_LOGIC: result_o = {{PAD_W{1'b0}}, logic_res};
            default:   result_o = '0;
        endcase
        flags_calc[FLAG_C] = calc_c;
        flags_calc[FLAG_V] = calc_v;
        flags_calc[FLAG_Z] = (result_o == '0);
        flags_calc[FLAG_N] = wide_eff ? result_o[WIDE_W-1] : result_o[NARROW_W-1];
    end

    // Commit: write-back and next flag state
    always_comb begin
        if (valid_i && cond_ok && (cls != CLS_NONE)) begin
            flags_next_o = flags_calc;
            wr_en_o      = ~no_write;
        end else begin
            flags_next_o = flags_o;
            wr_en_o      = 1'b0;
        end
    end

    dwc_flag_reg #(.FW(FLAG_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_d (flags_next_o),
        .flags_q (flags_o)
    );
endmodule

// File: rtl/dwc_alu_checker.sv
module dwc_alu_checker
    import dwc_alu_pkg::*;
#(
    parameter int WIDE_W = 24,
    parameter int NARROW_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_i,
    input logic [3:0]          op_i,
    input logic [1:0]          cond_i,
    input logic [WIDE_W-1:0]   result_o,
    input logic                wr_en_o,
    input logic [FLAG_W-1:0]   flags_next_o,
    input logic [FLAG_W-1:0]   flags_o
);
    logic is_cmp;
    logic is_logic;
    logic is_narrow_op;
    logic is_rsvd;
    logic cond_pass;

    always_comb begin
        is_cmp       = (op_i == OP_CMP) || (op_i == OP_CMC);
        is_logic     = (op_i >= OP_AND) && (op_i <= OP_NOT);
        is_rsvd      = (op_i > OP_NOT);
        is_narrow_op = !((op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_CMP));
        cond_pass    = (cond_i == CND_CSET) ? flags_o[FLAG_C] :
                       (cond_i == CND_CCLR) ? !flags_o[FLAG_C] : 1'b1;
    end

    a_r3_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> !wr_en_o);

    a_r8_cond_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i || !cond_pass) |-> (!wr_en_o && flags_next_o == flags_o));

    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(flags_o));

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        is_narrow_op |-> (result_o[WIDE_W-1:NARROW_W] == '0));

    a_r4_logic_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (is_logic && wr_en_o) |-> (!flags_next_o[FLAG_C] && !flags_next_o[FLAG_V]));

    a_r10_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
        is_rsvd |-> (!wr_en_o && result_o == '0 && flags_next_o == flags_o));

    a_r9_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flags_o == $past(flags_next_o)));

    a_r2_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && result_o != '0) |-> !flags_next_o[FLAG_Z]);
endmodule

bind dwc_alu dwc_alu_checker #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_dwc_alu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .valid_i      (valid_i),
    .op_i         (op_i),
    .cond_i       (cond_i),
    .result_o     (result_o),
    .wr_en_o      (wr_en_o),
    .flags_next_o (flags_next_o),
    .flags_o      (flags_o)
);

// File: tb/test_dwc_alu.sv
module test_dwc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic [1:0]  cond_i = '0;
    logic        use_imm_i = 1'b0;
    logic        imm_signed_i = 1'b0;
    logic [6:0]  imm_i = '0;
    logic [23:0] a_i = '0;
    logic [23:0] b_i = '0;
    logic [23:0] result_o;
    logic        wr_en_o;
    logic [3:0]  flags_next_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int failures = 0;
    logic [3:0] mflags = 4'h0;

    always #10 clk = ~clk;

    dwc_alu i_dwc_alu (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .wide_i(wide_i),
        .cond_i(cond_i), .use_imm_i(use_imm_i), .imm_signed_i(imm_signed_i),
        .imm_i(imm_i), .a_i(a_i), .b_i(b_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .flags_next_o(flags_next_o), .flags_o(flags_o)
    );

    // Returns {wr_en, flags_next[3:0], result[23:0]}
    function automatic logic [28:0] model(input logic vld, input logic [3:0] op,
            input logic wd, input logic [1:0] cnd, input logic ui, input logic is,
            input logic [6:0] im, input logic [23:0] a, input logic [23:0] b,
            input logic [3:0] fl);
        int w;
        longint mask, au, bu, r, sa, sb, s, ci, half;
        logic [23:0] bv, res;
        logic c, v, z, n, ok, pass, arith;
        w = (wd && (op == 0 || op == 1 || op == 4)) ? 24 : 16;
        mask = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        if (ui) bv = (is && im[6]) ? {17'h1FFFF, im} : {17'h0, im};
        else bv = b;
        au = longint'(a) & mask;
        bu = longint'(bv) & mask;
        sa = (au >= half) ? au - (mask + 1) : au;
        sb = (bu >= half) ? bu - (mask + 1) : bu;
        ci = (op == 2 || op == 3 || op == 5) ? longint'(fl[0]) : 0;
        c = 0; v = 0; arith = 1; res = '0;
        case (op)
            0, 2: begin
                r = au + bu + ci; s = sa + sb + ci;
                c = (r > mask); res = 24'(r & mask);
            end
            1, 3, 4, 5: begin
                r = au - bu - ci; s = sa - sb - ci;
                c = (r < 0); res = 24'(r & mask);
            end
            6: begin res = 24'(au & bu); arith = 0; end
            7: begin res = 24'(au | bu); arith = 0; end
            8: begin res = 24'(au ^ bu); arith = 0; end
            9: begin res = 24'(~bu & mask); arith = 0; end
            default: begin res = '0; arith = 0; end
        endcase
        if (arith) v = (s >= half) || (s < -half);
        z = (res == 0);
        n = res[w-1];
        pass = (cnd == 1) ? fl[0] : (cnd == 2) ? !fl[0] : 1'b1;
        ok = vld && (op <= 9) && pass;
        if (ok) return {ok && op != 4 && op != 5, v, n, z, c, res};
        return {1'b0, fl, res};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic vld, input logic [3:0] op,
            input logic wd, input logic [1:0] cnd, input logic ui, input logic is,
            input logic [6:0] im, input logic [23:0] a, input logic [23:0] b);
        logic [28:0] e;
        @(negedge clk);
        valid_i = vld; op_i = op; wide_i = wd; cond_i = cnd; use_imm_i = ui;
        imm_signed_i = is; imm_i = im; a_i = a; b_i = b;
        #5;
        e = model(vld, op, wd, cnd, ui, is, im, a, b, mflags);
        check(req, "result", {8'h0, result_o}, {8'h0, e[23:0]});
        check(req, "wr_en", {31'h0, wr_en_o}, {31'h0, e[28]});
        check(req, "flags_next", {28'h0, flags_next_o}, {28'h0, e[27:24]});
        @(posedge clk);
        #1;
        mflags = e[27:24];
        check("R9", "flags_reg", {28'h0, flags_o}, {28'h0, mflags});
    endtask

    function automatic logic [23:0] pick();
        case ($urandom_range(0, 5))
            0: return 24'h000000;
            1: return 24'hFFFFFF;
            2: return 24'h007FFF;
            3: return 24'h008000;
            4: return 24'h7FFFFF;
            default: return 24'($urandom);
        endcase
    endfunction

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #15;
        check("R9", "reset flags", {28'h0, flags_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 add, carry out at 16 bits
        apply("R1", 1, 4'd0, 0, 0, 0, 0, 7'h0, 24'h00FFFF, 24'h000001);
        // R2 signed overflow
        apply("R2", 1, 4'd0, 0, 0, 0, 0, 7'h0, 24'h007FFF, 24'h000001);
        // R5 wide add carry at 24 bits
        apply("R5", 1, 4'd0, 1, 0, 0, 0, 7'h0, 24'hFFFFFF, 24'h000001);
        // R1 borrow, then subtract-with-borrow using C
        apply("R1", 1, 4'd1, 0, 0, 0, 0, 7'h0, 24'h000000, 24'h000001);
        apply("R2", 1, 4'd3, 0, 0, 0, 0, 7'h0, 24'h008000, 24'h007FFF);
        // R7 conditional on C set / clear
        apply("R1", 1, 4'd1, 0, 0, 0, 0, 7'h0, 24'h000000, 24'h000001);
        apply("R7", 1, 4'd0, 0, 1, 0, 0, 7'h0, 24'h000010, 24'h000020);
        apply("R1", 1, 4'd1, 0, 0, 0, 0, 7'h0, 24'h000000, 24'h000001);
        apply("R8", 1, 4'd6, 0, 2, 0, 0, 7'h0, 24'h00FFFF, 24'h000000);
        apply("R2", 1, 4'd2, 0, 0, 0, 0, 7'h0, 24'h000001, 24'h000001);
        // R3 compare with borrow
        apply("R3", 1, 4'd5, 0, 0, 0, 0, 7'h0, 24'h000005, 24'h000004);
        // R6 immediates
        apply("R6", 1, 4'd0, 1, 0, 1, 1, 7'h7F, 24'h000010, 24'h0);
        apply("R6", 1, 4'd0, 0, 0, 1, 0, 7'h7F, 24'h000010, 24'h0);
        // R4 logic and NOT; R5 wide ignored for logic
        apply("R4", 1, 4'd9, 1, 0, 0, 0, 7'h0, 24'h123456, 24'hABCDEF);
        apply("R4", 1, 4'd8, 0, 0, 0, 0, 7'h0, 24'h00F0F0, 24'h00F0F0);
        // R10 reserved, R8 idle
        apply("R10", 1, 4'd12, 1, 0, 0, 0, 7'h0, 24'h111111, 24'h222222);
        apply("R8", 0, 4'd0, 0, 0, 0, 0, 7'h0, 24'h000000, 24'h000000);
        for (int i = 0; i < 4000; i++) begin
            apply("R1", ($urandom_range(0, 7) != 0), 4'($urandom_range(0, 11)),
                  1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                  7'($urandom), pick(), pick());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule